// File: doc/BRIEF.md
# Byte-Serialized Result Register Port

This block holds a small bank of 16-bit result words that an internal producer, such as a converter's result path, writes as whole words in a single clock. A bus master with an 8-bit data path reads each word as two byte accesses. Each word appears as two byte locations: the high byte at an even address and the low byte at the next odd address.

The master reads the high byte first. That access returns the high byte and, on the same clock edge, copies the word's low byte into one holding latch shared by all words. Any low-byte access returns the latch and never the live low byte. A high-then-low pair therefore yields one consistent 16-bit value, even if the producer overwrites the word between the two accesses.

A low-byte read that is not preceded by the matching high-byte read returns whatever the latch last captured. That is the intended behaviour, and the block does not correct it. Bus writes have no effect on the block.

Top module: `result_byte_port`

## Requirements
- R1: After a synchronous active-high reset, every result word, the shared latch and the read data output are zero.
- R2: A module-side write with `mod_we` high stores all 16 bits of `mod_data` into the word chosen by `mod_sel` in one clock, and a read on the following cycle observes the new value.
- R3: A bus read at an even address returns the high byte (bits 15:8) of the selected word on `bus_rdata` one clock after the read strobe.
- R4: A bus read at an even address loads the shared latch with the low byte (bits 7:0) of the selected word on the same edge. With a stored word of 0xAA40, a high-byte read returns 0xAA and the next low-byte read returns 0x40.
- R5: A bus read at any odd address returns the shared latch one clock after the strobe and not the live low byte of the addressed word. A low-byte read of word 1 right after a high-byte read of word 0 returns word 0's low byte.
- R6: Module-side writes leave the shared latch unchanged, so the low byte captured by a high-byte read survives a later overwrite of that word.
- R7: Bus writes (`bus_wr`) change neither the stored words nor the shared latch.
- R8: While `bus_rd` is low, `bus_rdata` holds its previous value.
- R9: Only a high-byte read loads the shared latch. Repeated low-byte reads return the same value.
- R10: Word n (n = 0 to 3) occupies bus address 2n for its high byte and 2n+1 for its low byte. Address bit 0 selects the byte, and bits 2:1 select the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_we | input | 1 | Module-side word write enable |
| mod_sel | input | 2 | Module-side word select |
| mod_data | input | 16 | Module-side write data |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe (ignored) |
| bus_addr | input | 3 | Bus byte address |
| bus_wdata | input | 8 | Bus write data (ignored) |
| bus_rdata | output | 8 | Registered bus read data |

## Verification
The bound checker examines four behaviours on every cycle. It confirms that read data holds while no read strobe is present, that the latch changes only on a high-byte read, that every low-byte read returns the latch value from the cycle before, and that reset clears the output.

The directed scenarios cover behaviour that depends on stored contents:
- the address map and whole-word writes from the producer side;
- the 0xAA40 split;
- stale low bytes read across different words;
- a latch surviving a producer overwrite between the two byte reads;
- bus writes leaving stored data untouched.

// File: rtl/result_byte_port.sv
module result_byte_port #(
  parameter int NREG   = 4,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mod_we,
  input  logic [$clog2(NREG)-1:0]  mod_sel,
  input  logic [WORD_W-1:0]        mod_data,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [$clog2(NREG):0]    bus_addr,
  input  logic [WORD_W/2-1:0]      bus_wdata,
  output logic [WORD_W/2-1:0]      bus_rdata
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int SEL_W  = $clog2(NREG);

  logic [WORD_W-1:0] word_q [NREG];
  logic [BYTE_W-1:0] lat_q;
  logic [SEL_W-1:0]  rd_sel;
  logic              rd_low;
  logic [WORD_W-1:0] rd_word;

  assign rd_sel  = bus_addr[SEL_W:1];
  assign rd_low  = bus_addr[0];
  assign rd_word = word_q[rd_sel];

  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[i] <= '0;
      else if (mod_we && mod_sel == SEL_W'(i))
        word_q[i] <= mod_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= '0;
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (rd_low) begin
        bus_rdata <= lat_q;
      end else begin
        bus_rdata <= rd_word[WORD_W-1:BYTE_W];
        lat_q     <= rd_word[BYTE_W-1:0];
      end
    end
  end

  logic unused_bus_w;
  assign unused_bus_w = bus_wr ^ (^bus_wdata);
endmodule

// File: rtl/result_byte_port_chk.sv
module result_byte_port_chk #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [BYTE_W-1:0] lat_q
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> bus_rdata == '0);

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r9_latch_only_on_high: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_addr[0]) |=> $stable(lat_q));

  a_r5_low_from_latch: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[0]) |=> bus_rdata == $past(lat_q));
endmodule

bind result_byte_port result_byte_port_chk #(
  .ADDR_W($clog2(NREG) + 1),
  .BYTE_W(WORD_W / 2)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .lat_q(lat_q)
);

// File: tb/result_byte_port_tb.sv
module result_byte_port_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       mod_we = 0;
  logic [1:0] mod_sel = '0;
  logic [15:0] mod_data = '0;
  logic       bus_rd = 0;
  logic       bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  result_byte_port u_dut (
    .clk(clk), .rst(rst), .mod_we(mod_we), .mod_sel(mod_sel), .mod_data(mod_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic mod_write(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); mod_we = 1; mod_sel = sel; mod_data = d;
    @(negedge clk); mod_we = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 rdata after reset", bus_rdata, 8'h00);
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), d);
      check("R1 word after reset", d, 8'h00);
    end
  endtask

  task automatic t_split;
    logic [7:0] d;
    mod_write(2'd0, 16'hAA40);
    bus_read(3'd0, d); check("R2 R3 high byte", d, 8'hAA);
    bus_read(3'd1, d); check("R4 low byte via latch", d, 8'h40);
  endtask

  task automatic t_map;
    logic [7:0] d;
    mod_write(2'd1, 16'h1234);
    mod_write(2'd2, 16'h5678);
    mod_write(2'd3, 16'h9ABC);
    bus_read(3'd2, d); check("R10 word1 high", d, 8'h12);
    bus_read(3'd3, d); check("R10 word1 low", d, 8'h34);
    bus_read(3'd4, d); check("R10 word2 high", d, 8'h56);
    bus_read(3'd5, d); check("R10 word2 low", d, 8'h78);
    bus_read(3'd6, d); check("R10 word3 high", d, 8'h9A);
    bus_read(3'd7, d); check("R10 word3 low", d, 8'hBC);
  endtask

  task automatic t_stale;
    logic [7:0] d;
    bus_read(3'd0, d); check("R3 word0 high", d, 8'hAA);
    bus_read(3'd3, d); check("R5 stale low from word0", d, 8'h40);
    bus_read(3'd7, d); check("R9 repeat low unchanged", d, 8'h40);
  endtask

  task automatic t_overwrite;
    logic [7:0] d;
    bus_read(3'd4, d); check("R3 word2 high", d, 8'h56);
    mod_write(2'd2, 16'hFFEE);
    bus_read(3'd5, d); check("R6 latch survives overwrite", d, 8'h78);
    bus_read(3'd4, d); check("R2 new word2 high", d, 8'hFF);
    bus_read(3'd5, d); check("R2 new word2 low", d, 8'hEE);
  endtask

  task automatic t_bus_write;
    logic [7:0] d;
    bus_read(3'd6, d); check("R3 word3 high", d, 8'h9A);
    bus_write(3'd7, 8'h11);
    bus_write(3'd6, 8'h22);
    bus_read(3'd7, d); check("R7 latch unchanged by bus write", d, 8'hBC);
    bus_write(3'd0, 8'h00);
    bus_write(3'd1, 8'h00);
    bus_read(3'd0, d); check("R7 word0 high unchanged", d, 8'hAA);
    bus_read(3'd1, d); check("R7 word0 low unchanged", d, 8'h40);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    bus_read(3'd2, d); check("R3 word1 high", d, 8'h12);
    repeat (3) @(negedge clk);
    check("R8 rdata holds while idle", bus_rdata, 8'h12);
    mod_write(2'd1, 16'h0000);
    check("R8 rdata holds across module write", bus_rdata, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_split();
    t_map();
    t_stale();
    t_overwrite();
    t_bus_write();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule